// File: doc/BRIEF.md
# Recirculating Longest-Prefix Lookup Engine

This block resolves 32-bit IPv4 destination addresses to forwarding results by walking a multi-level trie stored in one shared synchronous lookup memory. Each address arrives on a valid/ready input stream and immediately issues its first memory read, indexed by the upper half of the address. Each returned word is tested. A word with its top bit set is a leaf and ends the lookup. Any other word supplies a base pointer, and the request travels back around the loop to read the next level. A walk takes at most three reads.

Several lookups can be in flight at the same time, and they do not all need the same number of reads. A record travels with every outstanding read in a small in-order queue. The record holds the unused address bits, the walk level and a tag. The tag is drawn from an eight-slot completion buffer when the address enters. A finished walk writes its result into its own slot. The buffer then releases results strictly in arrival order on a valid/ready output stream. The memory is external and returns one word per request, in request order, marked by a response-valid flag. The table contents are loaded by the environment.

Top module: `lpm_engine`

## Requirements
- R1: When an address is accepted (in_valid and in_ready high before a clock edge), mem_req_valid is high in that same cycle and mem_req_index equals in_addr[31:16].
- R2: If the first response word has bit 31 clear, the next read index is the word's bits 15:0 plus in_addr[15:8], computed modulo 2^16.
- R3: If the second response word has bit 31 clear, the third read index is the word's bits 15:0 plus in_addr[7:0], computed modulo 2^16. The third response always ends the walk, and bits 30:0 of that word become the result whatever its bit 31 holds.
- R4: A response word with bit 31 set ends the walk, and its bits 30:0 become out_result for that address.
- R5: A response that needs another level is reissued to memory in the cycle it arrives. In that cycle in_ready is low, so a waiting address cannot take the port.
- R6: Exactly one result leaves for each accepted address, in the order the addresses were accepted, even when a later walk needs fewer reads.
- R7: At most 8 lookups are outstanding. With 8 accepted and none released, in_ready stays low.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_result does not change.
- R9: After reset, out_valid and mem_req_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Engine takes the offered address this cycle |
| in_addr | input | 32 | Destination address |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 31 | Lookup result (bits 30:0 of the final word) |
| mem_req_valid | output | 1 | Memory read issued this cycle |
| mem_req_index | output | 16 | Memory read index |
| mem_rsp_valid | input | 1 | Memory response present this cycle |
| mem_rsp_data | input | 32 | Memory response word; bit 31 marks a leaf |

## Verification
The collision of interest is a recirculating response that lands in the same cycle as a new address waiting at the input. Both want the single memory port. Back-to-back streams of mixed one-, two- and three-level addresses provoke this collision repeatedly. In every cycle with a non-final, non-leaf response, the bench checks that the reissued read owns the port and that in_ready is low, and it counts how many of those cycles had an address waiting. Every result is compared in order against an independent walk of the same table. This shows that the deferred address is neither lost nor reordered.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int IDX_W    = 16;
    localparam int STEP_W   = 8;
    localparam int NUM_TAGS = 8;
    localparam int TAG_W    = $clog2(NUM_TAGS);
    localparam int RES_W    = WORD_W - 1;
    localparam int REM_W    = ADDR_W - IDX_W;

    typedef logic [TAG_W-1:0] tag_t;

    typedef enum logic [1:0] {
        LVL_1 = 2'd0,
        LVL_2 = 2'd1,
        LVL_3 = 2'd2
    } lvl_e;

    // Record carried beside each outstanding memory read
    typedef struct packed {
        logic [REM_W-1:0] rem;
        tag_t             tag;
        lvl_e             lvl;
    } flight_t;

endpackage

// File: rtl/lpm_level_step.sv
module lpm_level_step
    import lpm_pkg::*;
(
    input  logic [WORD_W-1:0] rsp_word,
    input  flight_t           cur,
    output logic              finish,
    output logic [RES_W-1:0]  result,
    output logic [IDX_W-1:0]  next_index,
    output flight_t           next_entry
);

    logic [IDX_W-1:0]  base_ptr;
    logic [STEP_W-1:0] slice;

    always_comb begin
        base_ptr = rsp_word[IDX_W-1:0];
        // Level one consumes the upper remaining byte, level two the lower
        if (cur.lvl == LVL_1) begin
            slice = cur.rem[REM_W-1 -: STEP_W];
        end else begin
            slice = cur.rem[STEP_W-1:0];
        end
        next_index = base_ptr + IDX_W'(slice);
        finish     = rsp_word[WORD_W-1] || (cur.lvl == LVL_3);
        result     = rsp_word[RES_W-1:0];
        next_entry = cur;
        next_entry.lvl = (cur.lvl == LVL_1) ? LVL_2 : LVL_3;
    end

endmodule

// File: rtl/lpm_flight_fifo.sv
module lpm_flight_fifo
    import lpm_pkg::*;
#(
    parameter int DEPTH = NUM_TAGS
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  flight_t push_data,
    input  logic    pop,
    output flight_t head,
    output logic    full
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        flight_t [DEPTH-1:0] slot;
        logic [PW-1:0]       wp;
        logic [PW-1:0]       rp;
        logic [CW-1:0]       cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wp] = push_data;
            st_d.wp            = st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head = st_q.slot[st_q.rp];
    assign full = (st_q.cnt == CW'(DEPTH));

    // R5: every memory response must find its record waiting
    a_r5_rsp_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    // R5: a push with no matching pop never lands on a full queue
    a_r5_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (st_q.cnt != CW'(DEPTH)));

endmodule

// File: rtl/lpm_cbuf.sv
module lpm_cbuf
    import lpm_pkg::*;
#(
    parameter int SLOTS = NUM_TAGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    output tag_t             alloc_tag,
    output logic             can_alloc,
    input  logic             cmp_valid,
    input  tag_t             cmp_tag,
    input  logic [RES_W-1:0] cmp_result,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [RES_W-1:0] out_result
);

    localparam int CW = TAG_W + 1;

    typedef struct packed {
        logic [SLOTS-1:0]            done;
        logic [SLOTS-1:0][RES_W-1:0] res;
        tag_t                        wp;
        tag_t                        rp;
        logic [CW-1:0]               cnt;
    } cbuf_st_t;

    cbuf_st_t st_d, st_q;
    logic     release_fire;

    always_comb begin
        st_d         = st_q;
        release_fire = st_q.done[st_q.rp] && out_ready;
        if (alloc) begin
            st_d.wp = st_q.wp + 1'b1;
        end
        if (cmp_valid) begin
            st_d.done[cmp_tag] = 1'b1;
            st_d.res[cmp_tag]  = cmp_result;
        end
        if (release_fire) begin
            st_d.done[st_q.rp] = 1'b0;
            st_d.rp            = st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(alloc) - CW'(release_fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_tag  = st_q.wp;
    assign can_alloc  = (st_q.cnt < CW'(SLOTS));
    assign out_valid  = st_q.done[st_q.rp];
    assign out_result = st_q.res[st_q.rp];

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (st_q.cnt < CW'(SLOTS)));

    a_r6_complete_once: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> !st_q.done[cmp_tag]);

    a_r6_complete_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> ({1'b0, tag_t'(cmp_tag - st_q.rp)} < st_q.cnt));

    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

endmodule

// File: rtl/lpm_engine.sv
module lpm_engine
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RES_W-1:0]  out_result,
    output logic              mem_req_valid,
    output logic [IDX_W-1:0]  mem_req_index,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);

    flight_t          head, next_entry, push_data;
    logic             step_finish, recirc, accept, fifo_full, can_alloc;
    logic [RES_W-1:0] step_result;
    logic [IDX_W-1:0] next_index;
    tag_t             alloc_tag;

    lpm_level_step u_step (
        .rsp_word   (mem_rsp_data),
        .cur        (head),
        .finish     (step_finish),
        .result     (step_result),
        .next_index (next_index),
        .next_entry (next_entry)
    );

    always_comb begin
        // A walk still in progress owns the port before any new address
        recirc        = mem_rsp_valid && !step_finish;
        in_ready      = !recirc && can_alloc && !fifo_full;
        accept        = in_valid && in_ready;
        mem_req_valid = recirc || accept;
        if (recirc) begin
            mem_req_index = next_index;
            push_data     = next_entry;
        end else begin
            mem_req_index = in_addr[ADDR_W-1 -: IDX_W];
            push_data     = '{rem: in_addr[REM_W-1:0], tag: alloc_tag, lvl: LVL_1};
        end
    end

    lpm_flight_fifo #(.DEPTH(NUM_TAGS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mem_req_valid),
        .push_data (push_data),
        .pop       (mem_rsp_valid),
        .head      (head),
        .full      (fifo_full)
    );

    lpm_cbuf #(.SLOTS(NUM_TAGS)) u_cbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (accept),
        .alloc_tag  (alloc_tag),
        .can_alloc  (can_alloc),
        .cmp_valid  (mem_rsp_valid && step_finish),
        .cmp_tag    (head.tag),
        .cmp_result (step_result),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result)
    );

endmodule

// File: tb/lpm_engine_bench.sv
`timescale 1ns/1ps
module lpm_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [30:0] out_result;
    logic        mem_req_valid;
    logic [15:0] mem_req_index;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int checks = 0;
    int errors = 0;
    int collisions = 0;
    bit finished = 0;
    logic [30:0] exp_q[$];

    localparam logic [31:0] ODD_WORD = 32'h7EAD_1234;

    localparam int NVEC = 12;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0A00_8012, 32'h0700_1234, 32'h0A01_3344, 32'h0A01_9A05,
        32'h1234_5678, 32'h0A00_0101, 32'h0A00_FFFF, 32'hC0A8_0001,
        32'h0A01_0000, 32'h0000_0000, 32'h0A00_7F80, 32'h0A01_80FF
    };

    always #2.5 clk = ~clk;

    lpm_engine u_lpm_engine (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
        .mem_req_valid(mem_req_valid), .mem_req_index(mem_req_index),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Table contents as a function of the index
    function automatic logic [31:0] mw(input logic [15:0] i);
        if (i[15:12] == 4'hF) begin
            if (i[11:8] >= 4'd8) begin
                if (i == 16'hF9FF) mw = ODD_WORD;
                else               mw = {1'b1, 15'd3, i};
            end else if (i[11:8] <= 4'd1 && i[7]) begin
                mw = {16'h0, 16'hF800 + {4'h0, i[11:8], 8'h00}};
            end else begin
                mw = {1'b1, 15'd2, i};
            end
        end else if (i[15:8] == 8'h0A) begin
            mw = {16'h0, 16'hF000 + {7'h0, i[0], 8'h00}};
        end else begin
            mw = {1'b1, 15'd1, i};
        end
    endfunction

    function automatic logic [30:0] ref_walk(input logic [31:0] a);
        logic [31:0] p;
        p = mw(a[31:16]);
        if (p[31]) return p[30:0];
        p = mw(p[15:0] + {8'h0, a[15:8]});
        if (p[31]) return p[30:0];
        p = mw(p[15:0] + {8'h0, a[7:0]});
        return p[30:0];
    endfunction

    // Memory model: two-cycle read latency
    logic        s1_v, s2_v;
    logic [15:0] s1_i;
    logic [31:0] s2_d;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s2_v <= 1'b0; s1_i <= '0; s2_d <= '0;
        end else begin
            s1_v <= mem_req_valid; s1_i <= mem_req_index;
            s2_v <= s1_v;          s2_d <= mw(s1_i);
        end
    end
    assign mem_rsp_valid = s2_v;
    assign mem_rsp_data  = s2_d;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a);
        in_valid = 1'b1;
        in_addr  = a;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        exp_q.push_back(ref_walk(a));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitors, sampled well after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (in_valid && in_ready)   // R1
                chk(mem_req_valid && mem_req_index == in_addr[31:16], "R1 first index",
                    {15'h0, mem_req_valid, mem_req_index}, {16'h1, in_addr[31:16]});
            if (mem_rsp_valid && !mem_rsp_data[31] && mem_rsp_data != ODD_WORD) begin  // R5
                chk(mem_req_valid && !in_ready, "R5 recirculation priority",
                    {30'h0, mem_req_valid, in_ready}, 32'h2);
                if (in_valid) collisions++;
            end
            if (out_valid && out_ready) begin  // R6, R2, R3, R4
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected result", {1'b0, out_result}, 32'h0);
                end else begin
                    logic [30:0] e;
                    e = exp_q.pop_front();
                    chk(out_result == e, "R6/R4/R2/R3 ordered result", {1'b0, out_result}, {1'b0, e});
                end
            end
        end
    end

    task automatic drain();
        for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [30:0] held;
        repeat (3) @(negedge clk);
        #2;
        chk(!out_valid, "R9 out_valid after reset", out_valid, 0);
        chk(!mem_req_valid, "R9 mem_req_valid after reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(in_ready && !out_valid && !mem_req_valid, "R9 idle after reset",
            {in_ready, out_valid, mem_req_valid}, 3'b100);

        // Table walk: back-to-back mixed-depth stream
        @(negedge clk);
        for (int v = 0; v < NVEC; v++) send(VEC[v]);
        drain();
        chk(collisions > 0, "R5 collision provoked", collisions, 1);

        // Stalled output: fill all tags, ninth address must wait
        out_ready = 1'b0;
        @(negedge clk);
        for (int v = 0; v < 8; v++) send(VEC[v]);
        fork
            send(32'h0A01_9A05);
            begin
                repeat (20) @(negedge clk);
                #2;
                chk(in_ready == 1'b0, "R7 in_ready low with 8 outstanding", in_ready, 0);
                chk(out_valid == 1'b1, "R8 result presented", out_valid, 1);
                held = out_result;
                chk(out_result == ref_walk(VEC[0]), "R6 oldest result first",
                    {1'b0, out_result}, {1'b0, ref_walk(VEC[0])});
                repeat (5) @(negedge clk);
                #2;
                chk(out_valid && out_result == held, "R8 held while stalled",
                    {out_valid, out_result}, {1'b1, held});
                chk(mem_req_valid == 1'b0, "R7 no read while full", mem_req_valid, 0);
                @(negedge clk);
                out_ready = 1'b1;
            end
        join
        drain();

        // Deep lookup followed at once by shallow ones
        send(32'h0A01_80FF);
        send(32'h0700_0001);
        send(32'h0A00_0102);
        drain();
        #2;
        chk(!out_valid && in_ready, "R9 idle after drain", {out_valid, in_ready}, 2'b01);
        finish_run();
    end

endmodule